// File: doc/BRIEF.md
# Split Dual 8-bit Auto-Reload Timer

This block is a timer peripheral held in its split arrangement. It contains two independent 8-bit up-counters, a high half and a low half. Each half has its own reload register and its own choice of time base. When a half steps past 0xFF, it takes its reload value instead of 0x00 and sets its own sticky overflow flag. Software clears that flag later through the write port.

Every time base reaches the block as a one-cycle tick strobe that is synchronous to the single system clock. There are four of them: the plain system clock, the system clock divided by 12, an external clock divided by 8, and a low-frequency oscillator. A per-half mode bit picks either the plain system tick or the tick named by a shared two-bit select field. Only the high half is gated by a run bit; the low half counts whenever a tick arrives. The block raises a level interrupt request built from the flags, and a one-cycle trigger pulse that follows each wrap of the high half and is meant for a data converter.

Top module: `split_timer8`

## Requirements
- R1: After reset, both counts, both reload values and both flags are zero, and `irq` and `conv_trig` are low.
- R2: A half adds one to its count on each rising clock edge at which its selected tick is high. At all other edges its count holds.
- R3: The high half advances only while `run_hi` is 1. The low half ignores `run_hi`.
- R4: When a half's mode bit is 1, that half uses `tick_sys`. When the mode bit is 0, it uses the tick named by `ext_sel`: 2'b00 selects `tick_div12`, 2'b01 selects `tick_ext8`, and 2'b11 selects `tick_lfo`.
- R5: With `ext_sel` = 2'b10, a half whose mode bit is 0 does not count.
- R6: When a half advances from 0xFF, its count takes that half's reload value and its flag is set.
- R7: A write with `wr_addr` = 0 stores `wr_data` as the low reload value. A write with `wr_addr` = 1 stores it as the high reload value. A reload written in the same cycle as a wrap affects only later wraps. A write with `wr_addr` = 3 changes nothing.
- R8: Flags are sticky. A write with `wr_addr` = 2 clears the low flag if `wr_data[0]` is 1 and clears the high flag if `wr_data[1]` is 1. If a clear and a wrap land on the same flag at the same edge, the flag ends up set.
- R9: `irq` equals `irq_en` AND (`flag_hi` OR (`flag_lo` AND `lo_irq_en`)).
- R10: `conv_trig` is high for exactly the cycle that follows each edge at which the high half wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_sys | input | 1 | System-clock tick strobe |
| tick_div12 | input | 1 | System clock / 12 tick strobe |
| tick_ext8 | input | 1 | External clock / 8 tick strobe |
| tick_lfo | input | 1 | Low-frequency oscillator tick strobe |
| run_hi | input | 1 | Run control for the high half |
| mode_hi | input | 1 | High half: 1 = system tick, 0 = tick named by ext_sel |
| mode_lo | input | 1 | Low half: 1 = system tick, 0 = tick named by ext_sel |
| ext_sel | input | 2 | Shared selection of the alternative tick |
| irq_en | input | 1 | Interrupt enable for the whole block |
| lo_irq_en | input | 1 | Lets the low flag raise the interrupt too |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 low reload, 1 high reload, 2 flag clear, 3 unused |
| wr_data | input | 8 | Write data |
| cnt_lo | output | 8 | Low half count |
| cnt_hi | output | 8 | High half count |
| flag_lo | output | 1 | Low half overflow flag |
| flag_hi | output | 1 | High half overflow flag |
| irq | output | 1 | Interrupt request level |
| conv_trig | output | 1 | One-cycle pulse after a high-half wrap |

## Verification
Both counts are visible on the ports, so a wrong tick selection or a wrong run gate shows up as a count mismatch at the very next edge. A stale or wrongly written reload value stays hidden until the affected half wraps, which can take up to 256 ticks. For that reason the stimulus writes high reload values so that wraps come often. A flag that is lost, or that clears when it should not, changes `flag_*` and usually `irq` one cycle after the cause. A misplaced trigger shows as a `conv_trig` mismatch at that same edge.

// File: rtl/split_timer8.sv
module split_timer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_sys,
  input  logic         tick_div12,
  input  logic         tick_ext8,
  input  logic         tick_lfo,
  input  logic         run_hi,
  input  logic         mode_hi,
  input  logic         mode_lo,
  input  logic [1:0]   ext_sel,
  input  logic         irq_en,
  input  logic         lo_irq_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         flag_lo,
  output logic         flag_hi,
  output logic         irq,
  output logic         conv_trig
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] rld_lo, rld_hi;
  logic         alt_tick, step_lo, step_hi, wrap_lo, wrap_hi;
  logic         clr_lo, clr_hi;

  always_comb begin
    case (ext_sel)
      2'b00:   alt_tick = tick_div12;
      2'b01:   alt_tick = tick_ext8;
      2'b11:   alt_tick = tick_lfo;
      default: alt_tick = 1'b0;
    endcase
  end

  assign step_lo = mode_lo ? tick_sys : alt_tick;
  assign step_hi = run_hi & (mode_hi ? tick_sys : alt_tick);
  assign wrap_lo = step_lo & (cnt_lo == TOP);
  assign wrap_hi = step_hi & (cnt_hi == TOP);
  assign clr_lo  = wr_en & (wr_addr == 2'd2) & wr_data[0];
  assign clr_hi  = wr_en & (wr_addr == 2'd2) & wr_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_lo    <= '0;
      cnt_hi    <= '0;
      rld_lo    <= '0;
      rld_hi    <= '0;
      flag_lo   <= 1'b0;
      flag_hi   <= 1'b0;
      conv_trig <= 1'b0;
    end else begin
      if (step_lo) cnt_lo <= wrap_lo ? rld_lo : cnt_lo + 1'b1;
      if (step_hi) cnt_hi <= wrap_hi ? rld_hi : cnt_hi + 1'b1;
      if (wr_en && wr_addr == 2'd0) rld_lo <= wr_data;
      if (wr_en && wr_addr == 2'd1) rld_hi <= wr_data;
      flag_lo   <= wrap_lo | (flag_lo & ~clr_lo);
      flag_hi   <= wrap_hi | (flag_hi & ~clr_hi);
      conv_trig <= wrap_hi;
    end
  end

  assign irq = irq_en & (flag_hi | (flag_lo & lo_irq_en));
endmodule

module split_timer8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_hi,
  input logic         mode_lo,
  input logic [1:0]   ext_sel,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic         flag_lo,
  input logic         flag_hi,
  input logic         irq,
  input logic         conv_trig
);
  AST_HI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_hi |=> $stable(cnt_hi)); // R3
  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_lo && ext_sel == 2'b10) |=> $stable(cnt_lo)); // R5
  AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_lo) |-> (cnt_lo == $past(cnt_lo) + 1'b1 || $past(cnt_lo) == {W{1'b1}})); // R2
  AST_HI_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi && !(wr_en && wr_addr == 2'd2 && wr_data[1])) |=> flag_hi); // R8
  AST_LO_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_lo && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> flag_lo); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_hi && !flag_lo) |-> !irq); // R9
  AST_TRIG_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_trig |-> flag_hi); // R10
endmodule

bind split_timer8 split_timer8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_hi(run_hi), .mode_lo(mode_lo), .ext_sel(ext_sel),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(irq), .conv_trig(conv_trig)
);

// File: tb/split_timer8_test.sv
module split_timer8_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_sys = 0, tick_div12 = 0, tick_ext8 = 0, tick_lfo = 0;
  logic run_hi = 0, mode_hi = 0, mode_lo = 0, irq_en = 0, lo_irq_en = 0, wr_en = 0;
  logic [1:0] ext_sel = 0, wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] cnt_lo, cnt_hi;
  logic flag_lo, flag_hi, irq, conv_trig;

  int checks = 0, errors = 0;
  int m_lo = 0, m_hi = 0, r_lo = 0, r_hi = 0;
  bit f_lo = 0, f_hi = 0, trg = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  split_timer8 uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pick(bit mode);
    if (mode) return tick_sys;
    case (ext_sel)
      2'b00: return tick_div12;
      2'b01: return tick_ext8;
      2'b11: return tick_lfo;
      default: return 1'b0;
    endcase
  endfunction

  task automatic compare_all();
    chk("R2/R3/R4 cnt_lo", cnt_lo, m_lo);
    chk("R2/R3/R4 cnt_hi", cnt_hi, m_hi);
    chk("R6/R8 flag_lo", flag_lo, f_lo);
    chk("R6/R8 flag_hi", flag_hi, f_hi);
    chk("R9 irq", irq, irq_en && (f_hi || (f_lo && lo_irq_en)));
    chk("R10 conv_trig", conv_trig, trg);
  endtask

  task automatic model_step();
    bit a_lo, a_hi, w_lo, w_hi;
    a_lo = pick(mode_lo);
    a_hi = run_hi && pick(mode_hi);
    w_lo = a_lo && m_lo == 255;
    w_hi = a_hi && m_hi == 255;
    if (a_lo) m_lo = w_lo ? r_lo : m_lo + 1;
    if (a_hi) m_hi = w_hi ? r_hi : m_hi + 1;
    if (wr_en && wr_addr == 2) begin
      if (wr_data[0]) f_lo = 0;
      if (wr_data[1]) f_hi = 0;
    end
    if (w_lo) f_lo = 1;
    if (w_hi) f_hi = 1;
    if (wr_en && wr_addr == 0) r_lo = wr_data;
    if (wr_en && wr_addr == 1) r_hi = wr_data;
    trg = w_hi;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(int phase);
    int d = (phase == 5) ? 1 : 2;
    tick_sys   = ($urandom % d) == 0;
    tick_div12 = ($urandom % 2) == 0;
    tick_ext8  = ($urandom % 2) == 0;
    tick_lfo   = ($urandom % 3) == 0;
    run_hi     = (phase == 1) ? 1'b0 : (($urandom % 8) != 0);
    irq_en     = ($urandom % 4) != 0;
    lo_irq_en  = $urandom % 2;
    if (($urandom % 64) == 0) begin
      mode_hi = $urandom % 2;
      mode_lo = $urandom % 2;
      ext_sel = (phase == 2) ? 2'b10 : 2'($urandom);
    end
    wr_en   = ($urandom % 12) == 0;
    wr_addr = 2'($urandom);
    wr_data = (wr_addr < 2) ? (8'hE0 | 8'($urandom)) : 8'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cnt_lo reset", cnt_lo, 0);
    chk("R1 cnt_hi reset", cnt_hi, 0);
    chk("R1 flags reset", {flag_hi, flag_lo}, 0);
    chk("R1 irq/trig reset", {irq, conv_trig}, 0);
    rst_n = 1'b1;

    // R4 R2: mode 1, only tick_sys pulses, both halves count once per tick
    mode_hi = 1; mode_lo = 1; run_hi = 1; tick_sys = 1;
    model_step(); cycle();
    chk("R4 sys tick lo", cnt_lo, 1);
    tick_sys = 0; tick_div12 = 1; tick_lfo = 1;
    model_step(); cycle();
    chk("R2 unselected ticks ignored", cnt_hi, 1);

    // R5: reserved select holds both halves under mode 0
    mode_hi = 0; mode_lo = 0; ext_sel = 2'b10; tick_ext8 = 1;
    repeat (4) begin model_step(); cycle(); end
    chk("R5 reserved code holds lo", cnt_lo, 1);
    tick_div12 = 0; tick_lfo = 0; tick_ext8 = 0;

    // R7: write reloads, then address 3 has no effect
    wr_en = 1; wr_addr = 0; wr_data = 8'hFD; model_step(); cycle();
    wr_addr = 1; wr_data = 8'hFE; model_step(); cycle();
    wr_addr = 3; wr_data = 8'h55; model_step(); cycle();
    wr_en = 0;
    chk("R7 addr3 leaves counts", cnt_lo, 1);

    // R6 R10: run the low half to wrap using tick_sys, high half stopped (R3)
    mode_lo = 1; mode_hi = 1; run_hi = 0; tick_sys = 1;
    repeat (255) begin model_step(); cycle(); end
    chk("R6 lo reloads from reload reg", cnt_lo, 8'hFD);
    chk("R6 lo flag set", flag_lo, 1);
    chk("R3 hi frozen while run off", cnt_hi, 1);
    chk("R10 no trig from lo wrap", conv_trig, 0);

    // R8: clear and wrap in same cycle, set wins
    m_lo = m_lo;
    repeat (2) begin model_step(); cycle(); end
    wr_en = 1; wr_addr = 2; wr_data = 8'h01;
    model_step(); cycle();
    wr_en = 0;
    chk("R8 set beats clear", flag_lo, 1);
    tick_sys = 0;
    wr_en = 1; wr_addr = 2; wr_data = 8'h01; model_step(); cycle(); wr_en = 0;
    chk("R8 clear lo flag", flag_lo, 0);

    // randomized phases compared on every clock
    for (int ph = 0; ph < 6; ph++) begin
      for (int n = 0; n < 4000; n++) begin
        drive(ph);
        model_step();
        cycle();
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule